// File: doc/BRIEF.md
# Exception Entry Unit

This unit sits beside the execute stage of a 32-bit RISC core and turns three general fault sources into a single exception entry. The first source is a bad instruction in the slot after a delayed branch. The second is a strobe from the breakpoint comparators, which can fire before or after execution. The third is a DMA data access at a misaligned address. When a cause is present, the unit does the following in one clock:

- chooses a single winner among the causes;
- records the saved PC, the saved status and the event code;
- forces the mode, register-bank and block bits of the status register to 1;
- presents the new fetch PC, with a one-cycle taken pulse beside it.

Each cause saves a different PC. A slot fault saves the PC of the delayed branch. A pre-execution break saves the PC of the breakpoint instruction. A post-execution break saves the PC of the instruction after it. A DMA fault saves the PC of the next instruction. Transfers to or from the global base register are decoded as privileged, but the unit treats them as unprivileged.

All pins are plain control and status signals. The block carries no data stream, so there is no valid/ready handshake and no back-pressure. Every cause is sampled on the clock edge on which it is presented. The status register can also be loaded through a plain write strobe, which lets the core move between user and privileged mode.

Top module: `trap_entry_unit`

## Requirements
- R1: When `ins_valid` and `in_delay_slot` are both high and the instruction is flagged undefined (`ins_undef`) or PC-writing (`ins_pc_write`), an exception is taken. SPC receives `branch_pc` and the event code is 0x1A0. Without `in_delay_slot`, these flags raise nothing.
- R2: A slot instruction flagged privileged (`ins_priv`) raises the 0x1A0 fault only when SR bit 30 (MD) is 0, which is user mode. With MD = 1 it raises nothing.
- R3: A slot instruction flagged privileged that is also flagged as a global-base-register transfer (`ins_gbr_xfer`) never raises the slot fault, even in user mode.
- R4: `brk_pre` takes an exception with SPC = `brk_pc`. `brk_post` takes one with SPC = `brk_next_pc`. Both use event code 0x1E0. When both strobes are high, the pre-execution PC is saved.
- R5: `dma_size` encodes 0 = byte, 1 = word, 2 = longword, and 3 = reserved. A word fault occurs when `dma_addr[0]` = 1. A longword fault occurs when `dma_addr[1:0]` != 0. Byte and reserved sizes never fault. A fault saves `exec_next_pc` in SPC with event code 0x5C0.
- R6: When causes coincide, exactly one is taken. The slot fault wins over the DMA fault, and the DMA fault wins over the break.
- R7: On every exception, SSR receives the SR value held before entry. SR bits 30, 29 and 28 become 1, and all other SR bits keep their value.
- R8: `fetch_pc` becomes `vbr` + 0x100, and `exc_taken` is high for exactly the one cycle after the edge that captured the cause. Both outputs are registered.
- R9: `sr_wr_en` loads `sr_wr_data` into SR on a cycle with no exception. On a cycle that has an exception, the exception update of SR wins.
- R10: Reset clears SR, SPC, SSR, the event code, `fetch_pc` and `exc_taken` to zero. SR = 0 means the unit comes out of reset in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | A decoded instruction is present this cycle |
| in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| ins_undef | input | 1 | Instruction is an undefined code |
| ins_pc_write | input | 1 | Instruction rewrites the PC (jump, call, branch, return, trap, load into SR) |
| ins_priv | input | 1 | Instruction is in the privileged class |
| ins_gbr_xfer | input | 1 | Instruction is a transfer to or from the global base register |
| branch_pc | input | 32 | PC of the delayed branch before the slot |
| brk_pre | input | 1 | Pre-execution breakpoint match |
| brk_post | input | 1 | Post-execution breakpoint match |
| brk_pc | input | 32 | PC of the instruction that matched the breakpoint |
| brk_next_pc | input | 32 | PC of the instruction after the breakpoint instruction |
| dma_valid | input | 1 | A DMA data access is present this cycle |
| dma_addr | input | 32 | DMA access address |
| dma_size | input | 2 | DMA access size (0 byte, 1 word, 2 longword, 3 reserved) |
| exec_next_pc | input | 32 | PC following the last executed instruction |
| vbr | input | 32 | Vector base address |
| sr_wr_en | input | 1 | Load SR from `sr_wr_data` |
| sr_wr_data | input | 32 | New SR value |
| sr | output | 32 | Status register |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status register |
| expevt | output | 12 | Exception event code |
| exc_taken | output | 1 | One-cycle pulse marking an exception entry |
| fetch_pc | output | 32 | Handler fetch address |

## Verification
Every result appears one clock after its cause: the winner is captured on a rising edge, and SR, SPC, SSR, the event code, `exc_taken` and `fetch_pc` are all valid just after that same edge. The driver applies each stimulus on a falling edge and pushes the expected result into a queue at the same moment. The monitor pops one entry 1 ns after the following rising edge. Each comparison therefore lands on exactly the cycle in which the registered outputs change. Cycles with no exception are checked the same way, to confirm that SR is held or reloaded and that no pulse appears.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // cause indices, lowest index has highest priority
  localparam int NCAUSE  = 3;
  localparam int CI_SLOT = 0;
  localparam int CI_DMA  = 1;
  localparam int CI_BRK  = 2;

  localparam logic [11:0] EVT_SLOT = 12'h1A0;
  localparam logic [11:0] EVT_BRK  = 12'h1E0;
  localparam logic [11:0] EVT_DMA  = 12'h5C0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } dma_size_e;
endpackage

// File: rtl/trap_slot_check.sv
module trap_slot_check (
  input  logic ins_valid,
  input  logic in_delay_slot,
  input  logic ins_undef,
  input  logic ins_pc_write,
  input  logic ins_priv,
  input  logic ins_gbr_xfer,
  input  logic user_mode,
  output logic fault
);
  logic priv_eff;
  logic bad_kind;

  // transfers with the global base register are not privileged
  assign priv_eff = ins_priv & ~ins_gbr_xfer;
  assign bad_kind = ins_undef | ins_pc_write | (priv_eff & user_mode);
  assign fault    = ins_valid & in_delay_slot & bad_kind;
endmodule

// File: rtl/trap_dma_align.sv
module trap_dma_align
  import trap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          dma_valid,
  input  logic [AW-1:0] dma_addr,
  input  logic [1:0]    dma_size,
  output logic          fault
);
  logic [1:0] low;
  logic       unused_hi;
  logic       misaligned;

  assign low       = dma_addr[1:0];
  assign unused_hi = ^dma_addr[AW-1:2];

  always_comb begin
    unique case (dma_size_e'(dma_size))
      SZ_WORD: misaligned = low[0];
      SZ_LONG: misaligned = |low;
      default: misaligned = 1'b0;
    endcase
  end

  assign fault = dma_valid & misaligned;
endmodule

// File: rtl/trap_cause_arb.sv
module trap_cause_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          CODE_W  = 12,
  parameter int          MD_BIT  = 30,
  parameter int          RB_BIT  = 29,
  parameter int          BL_BIT  = 28,
  parameter logic [31:0] VEC_OFS = 32'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic              in_delay_slot,
  input  logic              ins_undef,
  input  logic              ins_pc_write,
  input  logic              ins_priv,
  input  logic              ins_gbr_xfer,
  input  logic [XLEN-1:0]   branch_pc,
  input  logic              brk_pre,
  input  logic              brk_post,
  input  logic [XLEN-1:0]   brk_pc,
  input  logic [XLEN-1:0]   brk_next_pc,
  input  logic              dma_valid,
  input  logic [XLEN-1:0]   dma_addr,
  input  logic [1:0]        dma_size,
  input  logic [XLEN-1:0]   exec_next_pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              sr_wr_en,
  input  logic [XLEN-1:0]   sr_wr_data,
  output logic [XLEN-1:0]   sr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   ssr,
  output logic [CODE_W-1:0] expevt,
  output logic              exc_taken,
  output logic [XLEN-1:0]   fetch_pc
);
  localparam logic [XLEN-1:0] ENTRY_MASK =
      (XLEN'(1) << MD_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << BL_BIT);
  localparam logic [XLEN-1:0] VEC_OFS_X = XLEN'(VEC_OFS);

  logic              slot_fault;
  logic              dma_fault;
  logic              brk_hit;
  logic              exc_req;
  logic [NCAUSE-1:0] req;
  logic [NCAUSE-1:0] grant;
  logic [XLEN-1:0]   spc_nxt;
  logic [XLEN-1:0]   brk_sel_pc;
  logic [CODE_W-1:0] code_nxt;

  trap_slot_check u_slot (
    .ins_valid     (ins_valid),
    .in_delay_slot (in_delay_slot),
    .ins_undef     (ins_undef),
    .ins_pc_write  (ins_pc_write),
    .ins_priv      (ins_priv),
    .ins_gbr_xfer  (ins_gbr_xfer),
    .user_mode     (~sr[MD_BIT]),
    .fault         (slot_fault)
  );

  trap_dma_align #(.AW(XLEN)) u_dma (
    .dma_valid (dma_valid),
    .dma_addr  (dma_addr),
    .dma_size  (dma_size),
    .fault     (dma_fault)
  );

  assign brk_hit = brk_pre | brk_post;

  always_comb begin
    req          = '0;
    req[CI_SLOT] = slot_fault;
    req[CI_DMA]  = dma_fault;
    req[CI_BRK]  = brk_hit;
  end

  trap_cause_arb #(.N(NCAUSE)) u_arb (
    .req   (req),
    .grant (grant)
  );

  assign exc_req    = |req;
  assign brk_sel_pc = brk_pre ? brk_pc : brk_next_pc;

  always_comb begin
    spc_nxt  = '0;
    code_nxt = '0;
    if (grant[CI_SLOT]) begin
      spc_nxt  = branch_pc;
      code_nxt = CODE_W'(EVT_SLOT);
    end else if (grant[CI_DMA]) begin
      spc_nxt  = exec_next_pc;
      code_nxt = CODE_W'(EVT_DMA);
    end else if (grant[CI_BRK]) begin
      spc_nxt  = brk_sel_pc;
      code_nxt = CODE_W'(EVT_BRK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      spc       <= '0;
      ssr       <= '0;
      expevt    <= '0;
      exc_taken <= 1'b0;
      fetch_pc  <= '0;
    end else begin
      exc_taken <= exc_req;
      if (exc_req) begin
        spc      <= spc_nxt;
        ssr      <= sr;
        expevt   <= code_nxt;
        sr       <= sr | ENTRY_MASK;
        fetch_pc <= vbr + VEC_OFS_X;
      end else if (sr_wr_en) begin
        sr <= sr_wr_data;
      end
    end
  end

  // R6: at most one cause granted
  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: a slot fault always wins
  a_r6_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault |=> expevt == CODE_W'(EVT_SLOT));

  // R1: slot fault saves the branch PC
  a_r1_slot_pc: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault |=> spc == $past(branch_pc));

  // R7: SSR takes the pre-entry SR
  a_r7_ssr_copy: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> ssr == $past(sr));

  // R7: control bits forced, others kept
  a_r7_sr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> ((sr & ENTRY_MASK) == ENTRY_MASK) &&
                  ((sr & ~ENTRY_MASK) == ($past(sr) & ~ENTRY_MASK)));

  // R8: handler address
  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> fetch_pc == $past(vbr) + VEC_OFS_X);

  // R9: plain SR load when no exception
  a_r9_sr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && sr_wr_en) |=> (sr == $past(sr_wr_data)) && !exc_taken);
endmodule

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
  typedef struct {
    string       tag;
    logic [31:0] sr;
    logic [31:0] spc;
    logic [31:0] ssr;
    logic [11:0] code;
    logic        taken;
    logic [31:0] fpc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, in_delay_slot = 0, ins_undef = 0, ins_pc_write = 0;
  logic ins_priv = 0, ins_gbr_xfer = 0, brk_pre = 0, brk_post = 0;
  logic dma_valid = 0, sr_wr_en = 0;
  logic [31:0] branch_pc = 0, brk_pc = 0, brk_next_pc = 0, dma_addr = 0;
  logic [31:0] exec_next_pc = 0, vbr = 0, sr_wr_data = 0;
  logic [1:0]  dma_size = 0;
  logic [31:0] sr, spc, ssr, fetch_pc;
  logic [11:0] expevt;
  logic        exc_taken;

  int errors = 0;
  int checks = 0;
  exp_t q[$];

  // model state
  logic [31:0] m_sr = 0, m_spc = 0, m_ssr = 0, m_fpc = 0;
  logic [11:0] m_code = 0;

  always #2.5 clk = ~clk;

  trap_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .in_delay_slot(in_delay_slot),
    .ins_undef(ins_undef), .ins_pc_write(ins_pc_write), .ins_priv(ins_priv),
    .ins_gbr_xfer(ins_gbr_xfer), .branch_pc(branch_pc), .brk_pre(brk_pre),
    .brk_post(brk_post), .brk_pc(brk_pc), .brk_next_pc(brk_next_pc),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_size(dma_size),
    .exec_next_pc(exec_next_pc), .vbr(vbr), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .sr(sr), .spc(spc), .ssr(ssr), .expevt(expevt),
    .exc_taken(exc_taken), .fetch_pc(fetch_pc)
  );

  task automatic clear_in();
    ins_valid = 0; in_delay_slot = 0; ins_undef = 0; ins_pc_write = 0;
    ins_priv = 0; ins_gbr_xfer = 0; brk_pre = 0; brk_post = 0;
    dma_valid = 0; sr_wr_en = 0;
  endtask

  // driver: inputs already placed by caller just after a falling edge
  task automatic push(input string tag);
    exp_t e;
    logic slot, dma, brk;
    slot = ins_valid && in_delay_slot &&
           (ins_undef || ins_pc_write || (ins_priv && !ins_gbr_xfer && !m_sr[30]));
    dma  = dma_valid && ((dma_size == 2'd1 && dma_addr[0]) ||
                         (dma_size == 2'd2 && dma_addr[1:0] != 2'b00));
    brk  = brk_pre || brk_post;
    e.taken = slot || dma || brk;
    if (e.taken) begin
      if (slot)     begin m_spc = branch_pc;    m_code = 12'h1A0; end
      else if (dma) begin m_spc = exec_next_pc; m_code = 12'h5C0; end
      else          begin m_spc = brk_pre ? brk_pc : brk_next_pc; m_code = 12'h1E0; end
      m_ssr = m_sr;
      m_sr  = m_sr | 32'h7000_0000;
      m_fpc = vbr + 32'h100;
    end else if (sr_wr_en) begin
      m_sr = sr_wr_data;
    end
    e.tag = tag; e.sr = m_sr; e.spc = m_spc; e.ssr = m_ssr;
    e.code = m_code; e.fpc = m_fpc;
    q.push_back(e);
    @(negedge clk);
    clear_in();
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sr !== e.sr || spc !== e.spc || ssr !== e.ssr || expevt !== e.code ||
          exc_taken !== e.taken || fetch_pc !== e.fpc) begin
        errors++;
        $display("FAIL %s: act sr=%h spc=%h ssr=%h evt=%h tk=%b fpc=%h exp sr=%h spc=%h ssr=%h evt=%h tk=%b fpc=%h",
                 e.tag, sr, spc, ssr, expevt, exc_taken, fetch_pc,
                 e.sr, e.spc, e.ssr, e.code, e.taken, e.fpc);
      end
    end
  end

  task automatic set_sr(input logic [31:0] v, input string tag);
    sr_wr_en = 1; sr_wr_data = v;
    push(tag);
  endtask

  initial begin
    vbr = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (sr !== 0 || spc !== 0 || ssr !== 0 || expevt !== 0 || exc_taken !== 0 || fetch_pc !== 0) begin
      errors++;
      $display("FAIL R10: act sr=%h spc=%h ssr=%h evt=%h tk=%b fpc=%h exp all zero",
               sr, spc, ssr, expevt, exc_taken, fetch_pc);
    end
    rst_n = 1;
    @(negedge clk);

    set_sr(32'h0000_00F3, "R9");
    // R1: undefined in slot
    ins_valid = 1; in_delay_slot = 1; ins_undef = 1; branch_pc = 32'h0000_1000;
    push("R1");
    set_sr(32'h0000_00F3, "R9");
    // R1: PC writer in slot
    ins_valid = 1; in_delay_slot = 1; ins_pc_write = 1; branch_pc = 32'h0000_2004;
    push("R1");
    set_sr(32'h0000_00F1, "R9");
    // R1: not in delay slot -> nothing
    ins_valid = 1; ins_undef = 1; ins_pc_write = 1; branch_pc = 32'h0000_3000;
    push("R1");
    // R2: privileged in user mode
    ins_valid = 1; in_delay_slot = 1; ins_priv = 1; branch_pc = 32'h0000_4008;
    push("R2");
    // R2: privileged mode -> nothing (SR MD already 1)
    ins_valid = 1; in_delay_slot = 1; ins_priv = 1; branch_pc = 32'h0000_5000;
    push("R2");
    set_sr(32'h0000_0001, "R9");
    // R3: GBR transfer in user mode -> no fault
    ins_valid = 1; in_delay_slot = 1; ins_priv = 1; ins_gbr_xfer = 1; branch_pc = 32'h0000_6000;
    push("R3");
    // R9: exception beats SR write
    sr_wr_en = 1; sr_wr_data = 32'h0000_0ABC; brk_pre = 1; brk_pc = 32'h0000_7000;
    push("R9");
    // R4: post-execution break
    vbr = 32'h9000_0000;
    brk_post = 1; brk_pc = 32'h0000_7100; brk_next_pc = 32'h0000_7102;
    push("R4");
    // R4: both strobes, pre wins
    brk_pre = 1; brk_post = 1; brk_pc = 32'h0000_7200; brk_next_pc = 32'h0000_7202;
    push("R4");
    // R5: all size/offset combos
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 4; off++) begin
        dma_valid = 1; dma_size = 2'(sz); dma_addr = 32'h1000_0040 + 32'(off);
        exec_next_pc = 32'h0000_8000 + 32'(sz * 16 + off * 2);
        push("R5");
      end
    end
    set_sr(32'h0000_0002, "R9");
    // R6: all three together -> slot
    ins_valid = 1; in_delay_slot = 1; ins_undef = 1; branch_pc = 32'h0000_9000;
    dma_valid = 1; dma_size = 2'd2; dma_addr = 32'h2; exec_next_pc = 32'h0000_9100;
    brk_pre = 1; brk_pc = 32'h0000_9200;
    push("R6");
    // R6: dma + break -> dma
    dma_valid = 1; dma_size = 2'd1; dma_addr = 32'h3; exec_next_pc = 32'h0000_9300;
    brk_post = 1; brk_next_pc = 32'h0000_9400;
    push("R6");
    // R8: back-to-back exceptions then idle
    brk_pre = 1; brk_pc = 32'h0000_A000;
    push("R8");
    push("R8");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: act running exp finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule